// File: doc/BRIEF.md
# Dithered Sub-Cycle PWM Generator

This block produces up to four pulse-width-modulated outputs from one free-running 8-bit counter that steps on every system clock. A full PWM period is 256 clocks. Each channel's 8-bit duty value sets how many of those 256 clocks the output is high. The period is cut into shorter sub-cycles so that the output toggles faster and a low-pass load sees less ripple. The duty value is split into a coarse high time, repeated in every sub-cycle, and a small dither count. The dither count lengthens the first few sub-cycles by one clock each, so the sum over the period is exact.

Two split modes are available. In the four-way split, each sub-cycle is 64 clocks long, the coarse part is duty bits 7..2 and the dither part is bits 1..0. In the two-way split, each sub-cycle is 128 clocks long, the coarse part is bits 7..1 and the dither part is bit 0. Duty writes go into a staging register and the mode select is a level input. Both are copied into the working registers only at the boundary between two full periods, so a change can never produce a malformed sub-cycle. Duty writes and mode changes are plain control inputs with no back-pressure: a write strobe is accepted on the clock edge where it is high.

Top module: `subcyc_pwm`

## Requirements
- R1: A shared 8-bit counter leaves reset at 0 and advances by one on every clock, wrapping from 255 to 0. Counter value 0 is the first clock of a full period, so a period is 256 clocks.
- R2: With mode_sel = 0 (four-way split), the sub-cycle index is counter bits 7..6, the position inside it is bits 5..0, the coarse value C is duty bits 7..2 and the dither value A is duty bits 1..0.
- R3: In the four-way split, sub-cycle i drives the output high at positions 0 through H-1 and low for the rest of its 64 clocks. H = C+1 when i < A, otherwise H = C.
- R4: With mode_sel = 1 (two-way split), the sub-cycle index is counter bit 7, the position is bits 6..0, C is duty bits 7..1 and A is duty bit 0.
- R5: In the two-way split, sub-cycle 0 is high for C+A clocks and sub-cycle 1 is high for C clocks, in each case starting at position 0 within the 128-clock sub-cycle.
- R6: For every duty value 0..255 in either mode, an enabled output is high for exactly that many clocks in one full period.
- R7: A sub-cycle whose high time is 0 keeps the output low for all of its clocks. Duty 0 gives an output that is low for the whole period.
- R8: A write with duty_we[n] high loads channel n's staging register. The value becomes active on the first clock of the next full period, and the period in progress keeps the old value.
- R9: A change of mode_sel during a period has no effect until the first clock of the next full period.
- R10: While ch_en[n] is low, pwm_out[n] is low on that same cycle. Re-enabling resumes the waveform at the current counter position.
- R11: Each channel has its own duty value. The four channels run side by side on the shared counter without affecting one another.
- R12: During reset all outputs are low. The active duty values reset to 0 and the active mode resets to the four-way split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter steps once per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | NUM_CH | Per-channel enable; low forces the output low |
| mode_sel | input | 1 | 0 = four 64-clock sub-cycles, 1 = two 128-clock sub-cycles; sampled at each period boundary |
| duty_we | input | NUM_CH | Per-channel write strobe for the staging duty register |
| duty_wdata | input | 8 | Duty value written to every channel whose strobe is high |
| pwm_out | output | NUM_CH | PWM outputs, one per channel |

## Verification
The bench builds the block with its default NUM_CH = 4. Each period therefore carries four different duty values, and the full 0..255 range is covered in 64 periods per mode instead of 256. Every period is checked clock by clock against the expected shape of each sub-cycle, including the high-time total. The next set of duties and the next mode are driven mid-period, so the deferred update is exercised on every period. The switch between the two modes, a mid-period disable and re-enable, and the all-zero duty are also covered.

// File: rtl/subcyc_pwm_pkg.sv
package subcyc_pwm_pkg;
  localparam int unsigned DUTY_W = 8;
  localparam int unsigned CNT_W  = DUTY_W;

  typedef enum logic {
    SPLIT_FOUR = 1'b0,
    SPLIT_TWO  = 1'b1
  } split_mode_e;
endpackage

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter
  import subcyc_pwm_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = (cnt_o == TOP);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt_o == W'($past(cnt_o) + 1'b1)) else $error("counter step"); // R1
endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow
  import subcyc_pwm_pkg::*;
#(
  parameter int unsigned W = DUTY_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] active_o
);
  logic [W-1:0] staged_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q <= '0;
      active_o <= '0;
    end else begin
      if (we)   staged_q <= wdata;
      if (load) active_o <= staged_q;
    end
  end

  AST_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> $stable(active_o)) else $error("duty changed mid period"); // R8
endmodule

// File: rtl/pwm_subcycle_cmp.sv
module pwm_subcycle_cmp
  import subcyc_pwm_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty,
  input  split_mode_e  mode,
  input  logic         en,
  output logic         out
);
  localparam int unsigned FOUR_AW = 2;
  localparam int unsigned TWO_AW  = 1;
  localparam int unsigned FOUR_CW = W - FOUR_AW;
  localparam int unsigned TWO_CW  = W - TWO_AW;

  // four-way split
  logic [FOUR_CW-1:0] f_coarse, f_pos;
  logic [FOUR_AW-1:0] f_dith, f_idx;
  logic [FOUR_CW:0]   f_high;
  logic               f_on;

  // two-way split
  logic [TWO_CW-1:0]  t_coarse, t_pos;
  logic               t_dith, t_idx;
  logic [TWO_CW:0]    t_high;
  logic               t_on;

  logic               sub_start;

  always_comb begin
    f_coarse = duty[W-1:FOUR_AW];
    f_dith   = duty[FOUR_AW-1:0];
    f_idx    = cnt[W-1:FOUR_CW];
    f_pos    = cnt[FOUR_CW-1:0];
    f_high   = {1'b0, f_coarse} + (FOUR_CW+1)'(f_idx < f_dith);
    f_on     = {1'b0, f_pos} < f_high;

    t_coarse = duty[W-1:TWO_AW];
    t_dith   = duty[0];
    t_idx    = cnt[W-1];
    t_pos    = cnt[TWO_CW-1:0];
    t_high   = {1'b0, t_coarse} + (TWO_CW+1)'(~t_idx & t_dith);
    t_on     = {1'b0, t_pos} < t_high;

    sub_start = (mode == SPLIT_TWO) ? (t_pos == '0) : (f_pos == '0);
    out       = en & ((mode == SPLIT_TWO) ? t_on : f_on);
  end

  AST_NO_MIDSUB_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !sub_start) |-> !(out && !$past(out))) else $error("rise inside sub-cycle"); // R3
endmodule

// File: rtl/subcyc_pwm.sv
module subcyc_pwm
  import subcyc_pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              mode_sel,
  input  logic [NUM_CH-1:0] duty_we,
  input  logic [DUTY_W-1:0] duty_wdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [CNT_W-1:0] cnt;
  logic             period_last;
  split_mode_e      mode_q;

  pwm_tick_counter #(.W(CNT_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_o  (cnt),
    .last_o (period_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           mode_q <= SPLIT_FOUR;
    else if (period_last) mode_q <= split_mode_e'(mode_sel);
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(mode_q)) else $error("mode changed mid period"); // R9

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic [DUTY_W-1:0] duty_act;

      pwm_duty_shadow #(.W(DUTY_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (duty_we[g]),
        .wdata    (duty_wdata),
        .load     (period_last),
        .active_o (duty_act)
      );

      pwm_subcycle_cmp #(.W(CNT_W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt),
        .duty  (duty_act),
        .mode  (mode_q),
        .en    (ch_en[g]),
        .out   (pwm_out[g])
      );
    end
  endgenerate

  AST_DIS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~ch_en) == '0) else $error("disabled channel active"); // R10
endmodule

// File: tb/subcyc_pwm_bench.sv
module subcyc_pwm_bench;
  localparam int NCH = 4;
  localparam time CLK_P = 8ns;

  logic           clk = 0;
  logic           rst_n = 0;
  logic [NCH-1:0] ch_en = '0;
  logic           mode_sel = 0;
  logic [NCH-1:0] duty_we = '0;
  logic [7:0]     duty_wdata = '0;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int fails  = 0;
  int unsigned tcnt = 0;

  logic [7:0] cur_d [NCH];
  logic [7:0] nxt_d [NCH];
  logic       cur_m, nxt_m;

  subcyc_pwm #(.NUM_CH(NCH)) u_subcyc_pwm (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .mode_sel(mode_sel),
    .duty_we(duty_we), .duty_wdata(duty_wdata), .pwm_out(pwm_out)
  );

  always #(CLK_P/2) clk = ~clk;

  // R1: expected counter position since reset release
  always @(posedge clk) begin
    if (!rst_n) tcnt <= 0;
    else        tcnt <= tcnt + 1;
  end

  function automatic logic [7:0] pos8();
    return tcnt[7:0];
  endfunction

  // Expected level from R2..R5
  function automatic logic exp_bit(logic [7:0] d, logic m, logic [7:0] c);
    int hi, pos, idx;
    if (m) begin
      idx = c[7]; pos = c[6:0];
      hi = int'(d[7:1]) + ((idx == 0 && d[0]) ? 1 : 0);
    end else begin
      idx = c[7:6]; pos = c[5:0];
      hi = int'(d[7:2]) + ((idx < int'(d[1:0])) ? 1 : 0);
    end
    return pos < hi;
  endfunction

  task automatic wait_pos(input logic [7:0] p);
    @(negedge clk);
    while (pos8() != p) @(negedge clk);
  endtask

  // One full period: check current duties/mode, stage next ones at position 100.
  // en_mid applies from position 128 when given.
  task automatic run_cycle(input logic [NCH-1:0] en_mid, input string tag);
    int hcnt [NCH];
    int bad  [NCH];
    int bpos [NCH];
    logic bact [NCH];
    logic [NCH-1:0] en_v;
    for (int c = 0; c < NCH; c++) begin hcnt[c] = 0; bad[c] = 0; bpos[c] = 0; bact[c] = 0; end
    wait_pos(8'd0);
    for (int i = 0; i < 256; i++) begin
      if (i > 0) @(negedge clk);
      en_v = ch_en;
      for (int c = 0; c < NCH; c++) begin
        logic e;
        e = en_v[c] & exp_bit(cur_d[c], cur_m, 8'(i));
        if (pwm_out[c]) hcnt[c]++;
        if (pwm_out[c] !== e && bad[c] == 0) begin bad[c] = 1; bpos[c] = i; bact[c] = pwm_out[c]; end
      end
      // stimulus after sampling
      duty_we = '0;
      if (i >= 100 && i < 100 + NCH) begin
        duty_we[i-100] = 1'b1;
        duty_wdata = nxt_d[i-100];
      end
      if (i == 100) mode_sel = nxt_m;   // R9: staged mid-period
      if (i == 128) ch_en = en_mid;     // R10
    end
    duty_we = '0;
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (bad[c] != 0) begin
        fails++;
        $display("FAIL %s ch%0d duty=%0d mode=%0d pos=%0d: actual %0b expected %0b",
                 tag, c, cur_d[c], cur_m, bpos[c], bact[c], ~bact[c]);
      end
    end
    for (int c = 0; c < NCH; c++) begin cur_d[c] = nxt_d[c]; end
    cur_m = nxt_m;
    // hcnt available for full-enable total checks
    for (int c = 0; c < NCH; c++) bpos[c] = hcnt[c];
    last_hcnt = bpos;
  endtask

  int last_hcnt [NCH];

  task automatic check_totals(input string tag);
    for (int c = 0; c < NCH; c++) begin
      checks++;
      if (last_hcnt[c] != int'(prev_d[c])) begin
        fails++;
        $display("FAIL %s ch%0d high clocks: actual %0d expected %0d", tag, c, last_hcnt[c], prev_d[c]);
      end
    end
  endtask

  logic [7:0] prev_d [NCH];

  task automatic t_reset();
    rst_n = 0; ch_en = '1;
    for (int c = 0; c < NCH; c++) begin cur_d[c] = 0; nxt_d[c] = 0; end
    cur_m = 0; nxt_m = 0;
    repeat (4) @(negedge clk);
    checks++;
    if (pwm_out !== '0) begin
      fails++; $display("FAIL R12 outputs in reset: actual %b expected 0000", pwm_out);
    end
    rst_n = 1;
    // R12/R7: period after reset uses active duty 0 in four-way mode
    for (int c = 0; c < NCH; c++) nxt_d[c] = 8'(c);
    nxt_m = 0;
    for (int c = 0; c < NCH; c++) prev_d[c] = cur_d[c];
    run_cycle('1, "R12 R7 reset zero duty");
    check_totals("R7 zero duty total");
  endtask

  // R2 R3 R6 R8 R11 (mode 0) / R4 R5 R6 R8 R11 (mode 1): all 256 duties
  task automatic t_sweep(input logic m, input logic m_after);
    for (int k = 0; k < 64; k++) begin
      for (int c = 0; c < NCH; c++) nxt_d[c] = (k < 63) ? 8'(4*(k+1) + c) : 8'(c);
      nxt_m = (k < 63) ? m : m_after;
      for (int c = 0; c < NCH; c++) prev_d[c] = cur_d[c];
      run_cycle('1, m ? "R4 R5 R8 R9 R11 two-way shape" : "R2 R3 R8 R9 R11 four-way shape");
      check_totals(m ? "R6 two-way total" : "R6 four-way total");
    end
  endtask

  // R10: disable mid-period, re-enable next period
  task automatic t_disable();
    nxt_d[0] = 8'hA5; nxt_d[1] = 8'h5A; nxt_d[2] = 8'hFF; nxt_d[3] = 8'h81; nxt_m = 1;
    run_cycle('1, "R9 R8 setup");
    run_cycle(4'b0101, "R10 disable mid-period");
    run_cycle('1, "R10 re-enable resumes");
    for (int c = 0; c < NCH; c++) prev_d[c] = cur_d[c];
    run_cycle('1, "R10 R5 full enable");
    check_totals("R6 R10 total after re-enable");
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_sweep(1'b0, 1'b1);
    t_sweep(1'b1, 1'b0);
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule